// File: doc/BRIEF.md
# PLL Bring-Up and Lock Sequencer

This block starts a PHY reference PLL without help from a processor. A single-cycle `start` pulse launches a fixed program. The program runs on a simple register master port, one transaction at a time. It first reads the PLL status word. If the PLL already reports lock, the block only makes sure the PLL is awake. If it finds the idle request set, it clears that bit and then waits for lock again. If the PLL is not locked, the block picks divider and multiplier settings from a built-in table, keyed on the system clock rate given in kHz. It then updates five configuration fields, each with a read-modify-write. After that it writes the go command and polls for lock, once per prescaled tick, with a bounded number of attempts.

The master port works as a valid/ready pair. `bus_rd` or `bus_wr` is the valid, and `bus_ack` from the register target is the ready. Once a request is raised, its address, data and direction stay frozen until the target raises `bus_ack`. The target may stall for any number of cycles. Read data is taken in the cycle in which `bus_ack` is high. At most one request is open at a time, and the next one never starts in that same cycle.

At the end of the program, `done` pulses for one cycle. `err_code` and `locked` then hold the result until the next start.

Top module: `pll_lock_seq`

## Requirements
- R1: After reset `done`, `err_code`, `locked`, `bus_rd` and `bus_wr` are all 0.
- R2: `bus_rd` and `bus_wr` are never high together, and an open request keeps its address, data and direction unchanged until `bus_ack`.
- R3: The first transaction after `start` is a read of the status word at address 0x04, whose bit 1 means locked.
- R4: When unlocked, five read-modify-writes follow, each a read then a write of the same address. Only the field's bits change. The order is: 0x0C bits [8:1] (N), 0x10 bits [3:1] (DCO select), 0x0C bits [20:9] (M), 0x20 bits [17:0] (fractional M), 0x14 bits [17:10] (SD).
- R5: The rate table in kHz gives M as follows: 12000→1000, 16800→714, 19200→625, 20000→600, 26000→461, 38400→312. Every entry uses N=7, DCO=4, SD=6 and fractional M=0.
- R6: After the SD write, the value 1 is written to the go register at 0x08, and lock polling begins.
- R7: A rate missing from the table ends the run after the status read with `err_code`=1 and no write.
- R8: When status shows lock and bit 0 (idle) of 0x10 is set, 0x10 is written back with only bit 0 cleared, and lock polling begins.
- R9: When status shows lock and the idle bit is clear, the run ends after the 0x10 read with `locked`=1, `err_code`=0 and no write.
- R10: Polling reads status once every `TICK_CYCLES` waiting cycles. The first read showing lock ends the run with `locked`=1 and `err_code`=0.
- R11: After `POLL_LIMIT` status reads without lock, the run ends with `err_code`=2 and `locked`=0.
- R12: `start` pulses while a run is in progress have no effect. `done` pulses once per run and is followed by no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| rate_khz | input | RATE_W | System clock rate in kHz |
| bus_addr | output | 8 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_rd | output | 1 | Read request (valid) |
| bus_wr | output | 1 | Write request (valid) |
| bus_ack | input | 1 | Target accepts the open request (ready) |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 none, 1 rate not in table, 2 lock timeout |
| locked | output | 1 | Run ended with the PLL locked |

## Verification
The bench builds the block with `TICK_CYCLES`=3 and `POLL_LIMIT`=6. With these values a lock timeout takes a few dozen cycles rather than millions, so the exhausted-poll path and the exact poll count can be checked directly. The register target stalls for 0, 1 or 2 cycles, which tests that requests hold steady under back-pressure. Initial register values with bits set all around each field show whether the read-modify-writes preserve the neighbouring bits.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NFIELD = 5;

  localparam logic [ADDR_W-1:0] A_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] A_GO   = 8'h08;
  localparam logic [ADDR_W-1:0] A_CF1  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CF2  = 8'h10;
  localparam logic [ADDR_W-1:0] A_CF3  = 8'h14;
  localparam logic [ADDR_W-1:0] A_CF4  = 8'h20;

  localparam int LOCK_BIT = 1;
  localparam int IDLE_BIT = 0;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_INVAL = 2'd1;
  localparam logic [1:0] ERR_BUSY  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_STAT, S_WAKE_RD, S_WAKE_WR, S_RMW_RD,
    S_RMW_WR, S_GO, S_WAIT, S_POLL, S_END
  } state_t;

  typedef struct packed {
    logic [11:0] mul;
    logic [7:0]  div;
    logic [2:0]  dco;
    logic [7:0]  sdv;
    logic [17:0] frac;
  } pll_cfg_t;

  // Field order is the write order.
  function automatic logic [ADDR_W-1:0] fld_addr(input logic [2:0] i);
    case (i)
      3'd0: fld_addr = A_CF1;
      3'd1: fld_addr = A_CF2;
      3'd2: fld_addr = A_CF1;
      3'd3: fld_addr = A_CF4;
      default: fld_addr = A_CF3;
    endcase
  endfunction

  function automatic int fld_lsb(input logic [2:0] i);
    case (i)
      3'd0: fld_lsb = 1;
      3'd1: fld_lsb = 1;
      3'd2: fld_lsb = 9;
      3'd3: fld_lsb = 0;
      default: fld_lsb = 10;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] fld_mask(input logic [2:0] i);
    case (i)
      3'd0: fld_mask = 32'h0000_01FE;
      3'd1: fld_mask = 32'h0000_000E;
      3'd2: fld_mask = 32'h001F_FE00;
      3'd3: fld_mask = 32'h0003_FFFF;
      default: fld_mask = 32'h0003_FC00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] fld_val(input logic [2:0] i, input pll_cfg_t c);
    case (i)
      3'd0: fld_val = DATA_W'(c.div);
      3'd1: fld_val = DATA_W'(c.dco);
      3'd2: fld_val = DATA_W'(c.mul);
      3'd3: fld_val = DATA_W'(c.frac);
      default: fld_val = DATA_W'(c.sdv);
    endcase
  endfunction
endpackage

// File: rtl/pls_rate_table.sv
module pls_rate_table
  import pls_pkg::*;
#(
  parameter int RATE_W = 20
) (
  input  logic [RATE_W-1:0] rate_khz,
  output logic              hit,
  output pll_cfg_t          cfg
);
  always_comb begin
    hit      = 1'b1;
    cfg.div  = 8'd7;
    cfg.dco  = 3'd4;
    cfg.sdv  = 8'd6;
    cfg.frac = 18'd0;
    case (rate_khz)
      RATE_W'(12000): cfg.mul = 12'd1000;
      RATE_W'(16800): cfg.mul = 12'd714;
      RATE_W'(19200): cfg.mul = 12'd625;
      RATE_W'(20000): cfg.mul = 12'd600;
      RATE_W'(26000): cfg.mul = 12'd461;
      RATE_W'(38400): cfg.mul = 12'd312;
      default: begin
        cfg.mul = 12'd0;
        hit     = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pls_tick.sv
module pls_tick #(
  parameter int CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
  import pls_pkg::*;
#(
  parameter int TICK_CYCLES = 100000,
  parameter int POLL_LIMIT  = 100,
  parameter int RATE_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_khz,
  output logic [7:0]        bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              bus_ack,
  output logic              done,
  output logic [1:0]        err_code,
  output logic              locked
);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  state_t          st;
  logic [2:0]      idx;
  logic [31:0]     hold;
  pll_cfg_t        cfg_q, cfg_lut;
  logic            hit, tick;
  logic [PW-1:0]   polls;
  logic [1:0]      err_q;
  logic            locked_q;
  logic [31:0]     fmask, fins;

  pls_rate_table #(.RATE_W(RATE_W)) u_tab (
    .rate_khz(rate_khz), .hit(hit), .cfg(cfg_lut)
  );

  pls_tick #(.CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(st == S_WAIT), .tick(tick)
  );

  always_comb begin
    fmask = fld_mask(idx);
    fins  = (fld_val(idx, cfg_q) << fld_lsb(idx)) & fmask;
  end

  always_comb begin
    bus_rd    = (st == S_STAT) || (st == S_WAKE_RD) || (st == S_RMW_RD) || (st == S_POLL);
    bus_wr    = (st == S_WAKE_WR) || (st == S_RMW_WR) || (st == S_GO);
    bus_wdata = hold;
    case (st)
      S_WAKE_RD, S_WAKE_WR: bus_addr = A_CF2;
      S_RMW_RD, S_RMW_WR:   bus_addr = fld_addr(idx);
      S_GO:                 bus_addr = A_GO;
      default:              bus_addr = A_STAT;
    endcase
  end

  assign done     = (st == S_END);
  assign err_code = err_q;
  assign locked   = locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      hold     <= '0;
      cfg_q    <= '0;
      polls    <= '0;
      err_q    <= ERR_NONE;
      locked_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_STAT;
          err_q    <= ERR_NONE;
          locked_q <= 1'b0;
        end
        S_STAT: if (bus_ack) begin
          if (bus_rdata[LOCK_BIT]) st <= S_WAKE_RD;
          else if (!hit) begin
            err_q <= ERR_INVAL;
            st    <= S_END;
          end else begin
            cfg_q <= cfg_lut;
            idx   <= '0;
            st    <= S_RMW_RD;
          end
        end
        S_WAKE_RD: if (bus_ack) begin
          if (bus_rdata[IDLE_BIT]) begin
            hold <= bus_rdata & ~(32'd1 << IDLE_BIT);
            st   <= S_WAKE_WR;
          end else begin
            locked_q <= 1'b1;
            st       <= S_END;
          end
        end
        S_WAKE_WR: if (bus_ack) begin
          polls <= '0;
          st    <= S_WAIT;
        end
        S_RMW_RD: if (bus_ack) begin
          hold <= (bus_rdata & ~fmask) | fins;
          st   <= S_RMW_WR;
        end
        S_RMW_WR: if (bus_ack) begin
          if (idx == 3'(NFIELD - 1)) begin
            hold <= 32'd1;
            st   <= S_GO;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_RMW_RD;
          end
        end
        S_GO: if (bus_ack) begin
          polls <= '0;
          st    <= S_WAIT;
        end
        S_WAIT: if (tick) st <= S_POLL;
        S_POLL: if (bus_ack) begin
          if (bus_rdata[LOCK_BIT]) begin
            locked_q <= 1'b1;
            st       <= S_END;
          end else if (polls == PW'(POLL_LIMIT - 1)) begin
            err_q <= ERR_BUSY;
            st    <= S_END;
          end else begin
            polls <= polls + 1'b1;
            st    <= S_WAIT;
          end
        end
        S_END: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pls_chk.sv
module pls_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        bus_ack,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        done,
  input logic [1:0]  err_code,
  input logic        locked
);
  // R2
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R2
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !bus_ack) |=>
      ($stable(bus_rd) && $stable(bus_wr) && $stable(bus_addr) && $stable(bus_wdata)));

  // R10
  lock_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && locked) |-> (err_code == 2'd0));

  // R11
  timeout_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd2) |-> !locked);

  // R7
  inval_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd1) |-> !locked);

  // R12
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !bus_rd && !bus_wr));
endmodule

bind pll_lock_seq pls_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .done(done), .err_code(err_code),
  .locked(locked)
);

// File: tb/sim_pll_lock_seq.sv
module sim_pll_lock_seq;
  localparam int TICKS = 3;
  localparam int POLLS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] rate_khz = '0;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_rd, bus_wr;
  logic        bus_ack = 1'b0;
  logic        done;
  logic [1:0]  err_code;
  logic        locked;

  always #5 clk = ~clk;

  pll_lock_seq #(.TICK_CYCLES(TICKS), .POLL_LIMIT(POLLS), .RATE_W(20)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_khz(rate_khz),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack),
    .done(done), .err_code(err_code), .locked(locked)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Expected transaction list
  bit          q_we[$];
  logic [7:0]  q_addr[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  task automatic push(input bit we, input logic [7:0] a, input logic [31:0] d, input string t);
    q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  // Register target model
  logic [31:0] r_cf1, r_cf2, r_cf3, r_cf4, r_go;
  bit  lk_state, armed, pre_lk_g;
  int  polls_seen, lock_after, lat, wait_cnt, writes_seen;
  bit  fin_pend, done_seen, active;
  logic [1:0] done_err;
  bit  done_lock;

  function automatic logic [31:0] reg_rd(input logic [7:0] a);
    case (a)
      8'h04: begin
        if (armed) begin
          polls_seen++;
          reg_rd = {30'd0, (polls_seen >= lock_after), 1'b0};
        end else reg_rd = {30'd0, lk_state, 1'b0};
      end
      8'h08: reg_rd = r_go;
      8'h0C: reg_rd = r_cf1;
      8'h10: reg_rd = r_cf2;
      8'h14: reg_rd = r_cf3;
      8'h20: reg_rd = r_cf4;
      default: reg_rd = 32'h0;
    endcase
  endfunction

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    writes_seen++;
    case (a)
      8'h08: begin r_go = d; armed = 1; polls_seen = 0; end
      8'h0C: r_cf1 = d;
      8'h10: begin r_cf2 = d; if (pre_lk_g) begin armed = 1; polls_seen = 0; end end
      8'h14: r_cf3 = d;
      8'h20: r_cf4 = d;
      default: ;
    endcase
  endtask

  // Per-clock target and reference comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && active) begin
      if (fin_pend) begin
        chk("R12 done pulse after last transaction", {31'd0, done}, 32'd1);
        fin_pend  = 0;
        done_seen = 1;
        done_err  = err_code;
        done_lock = locked;
      end else if (done) begin
        chk("R12 unexpected done", {31'd0, done}, 32'd0);
      end
      if (bus_ack) begin
        bus_ack  = 1'b0;
        wait_cnt = 0;
      end else if (bus_rd || bus_wr) begin
        if (wait_cnt == lat) begin
          bus_ack = 1'b1;
          if (q_we.size() == 0) begin
            chk("R2 transaction beyond expected list", {bus_wr, bus_addr}, 32'hFFFF);
          end else begin
            string t;
            t = q_tag.pop_front();
            chk(t, {31'd0, bus_wr}, {31'd0, q_we.pop_front()});
            chk(t, {24'd0, bus_addr}, {24'd0, q_addr.pop_front()});
            if (bus_wr) chk(t, bus_wdata, q_data.pop_front());
            else void'(q_data.pop_front());
            if (q_we.size() == 0) fin_pend = 1;
          end
          if (bus_wr) reg_wr(bus_addr, bus_wdata);
          else bus_rdata = reg_rd(bus_addr);
        end else wait_cnt++;
      end
    end
  end

  function automatic int ref_mul(input int khz);
    case (khz)
      12000: ref_mul = 1000;
      16800: ref_mul = 714;
      19200: ref_mul = 625;
      20000: ref_mul = 600;
      26000: ref_mul = 461;
      38400: ref_mul = 312;
      default: ref_mul = -1;
    endcase
  endfunction

  task automatic run(input string tag, input int khz, input bit pre_lk, input bit idle,
                     input int lk_n, input int l, input bit glitch,
                     input logic [1:0] exp_err, input bit exp_lock);
    logic [31:0] c1a, c1b, c2a, c3a, c4a;
    int m, expect_polls;
    r_cf1 = 32'hDEAD_BEEF; r_cf2 = 32'h1234_567E | {31'd0, idle};
    r_cf3 = 32'hCAFE_F00D; r_cf4 = 32'h8765_4321; r_go = 0;
    lk_state = pre_lk; pre_lk_g = pre_lk; armed = 0; polls_seen = 0;
    lock_after = lk_n; lat = l; wait_cnt = 0; writes_seen = 0;
    fin_pend = 0; done_seen = 0;
    q_we.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
    m = ref_mul(khz);
    expect_polls = (lk_n > POLLS) ? POLLS : lk_n;
    push(0, 8'h04, 0, "R3 status read first");
    if (pre_lk) begin
      push(0, 8'h10, 0, "R9 idle probe read");
      if (idle) begin
        push(1, 8'h10, r_cf2 & ~32'h1, "R8 idle clear write");
        for (int i = 0; i < expect_polls; i++) push(0, 8'h04, 0, "R10 poll read");
      end
    end else if (m >= 0) begin
      c1a = (r_cf1 & ~32'h0000_01FE) | (32'd7 << 1);
      c2a = (r_cf2 & ~32'h0000_000E) | (32'd4 << 2 >> 1);
      c1b = (c1a & ~32'h001F_FE00) | (32'(m) << 9);
      c4a = r_cf4 & ~32'h0003_FFFF;
      c3a = (r_cf3 & ~32'h0003_FC00) | (32'd6 << 10);
      push(0, 8'h0C, 0, "R4 N read");     push(1, 8'h0C, c1a, "R4 N write");
      push(0, 8'h10, 0, "R4 DCO read");   push(1, 8'h10, c2a, "R4 DCO write");
      push(0, 8'h0C, 0, "R4 M read");     push(1, 8'h0C, c1b, "R5 M write");
      push(0, 8'h20, 0, "R4 MF read");    push(1, 8'h20, c4a, "R4 MF write");
      push(0, 8'h14, 0, "R4 SD read");    push(1, 8'h14, c3a, "R4 SD write");
      push(1, 8'h08, 32'd1, "R6 go write");
      for (int i = 0; i < expect_polls; i++) push(0, 8'h04, 0, "R10 poll read");
    end
    @(negedge clk); rate_khz = 20'(khz); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 3000 && !done_seen; c++) begin
      if (glitch && c == 8) begin
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
      @(posedge clk);
    end
    chk({tag, " run finished"}, {31'd0, done_seen}, 32'd1);
    chk({tag, " err_code"}, {30'd0, done_err}, {30'd0, exp_err});
    chk({tag, " locked"}, {31'd0, done_lock}, {31'd0, exp_lock});
    chk({tag, " transactions left"}, q_we.size(), 0);
    if (m < 0 && !pre_lk) chk("R7 no write on bad rate", writes_seen, 0);
    if (pre_lk && !idle)  chk("R9 no write when awake", writes_seen, 0);
    if (pre_lk && idle)   chk("R8 other bits kept", r_cf2, 32'h1234_567E);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    active = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done at reset", {31'd0, done}, 32'd0);
    chk("R1 err at reset", {30'd0, err_code}, 32'd0);
    chk("R1 locked at reset", {31'd0, locked}, 32'd0);
    chk("R1 strobes at reset", {30'd0, bus_rd, bus_wr}, 32'd0);
    rst_n = 1'b1;
    active = 1;
    repeat (2) @(posedge clk);
    run("R5 12MHz",          12000, 0, 0, 2,    0, 0, 2'd0, 1);
    run("R5/R12 38.4MHz",    38400, 0, 0, 1,    2, 1, 2'd0, 1);
    run("R5 16.8MHz",        16800, 0, 0, 3,    1, 0, 2'd0, 1);
    run("R5 19.2MHz",        19200, 0, 0, 1,    0, 0, 2'd0, 1);
    run("R5 20MHz",          20000, 0, 0, 1,    1, 0, 2'd0, 1);
    run("R7 bad rate",       25000, 0, 0, 1,    1, 0, 2'd1, 0);
    run("R8 wake from idle", 26000, 1, 1, 2,    1, 0, 2'd0, 1);
    run("R9 already awake",  26000, 1, 0, 1,    0, 0, 2'd0, 1);
    run("R11 lock timeout",  26000, 0, 0, 1000, 0, 0, 2'd2, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule